// File: doc/BRIEF.md
# CAMAC Dataway Cycle Controller

This block sits between a host's 16-bit I/O bus and one CAMAC crate dataway. The host sees four word registers at a parameter base address. Through them it stages 24 bits of outgoing data, sets the Inhibit and general output lines, and reads back the captured response and the LAM request lines. One register holds the station, subaddress and function word. Writing that word is the only way to start a dataway operation.

Once started, a sequencer steps through a fixed timing pattern. It drives N/A/F first, then pulses strobe S1, then pulses strobe S2, and then returns to idle. Each phase lasts a parameter number of clocks. The response (read data, Q, X) is captured at the end of S1. Two bits of the same command word select an unaddressed clear (C) or initialise (Z) operation instead of an addressed one.

Top module: `camac_host_ctl`

## Requirements
- R1: Only the four word addresses BASE+0, BASE+2, BASE+4 and BASE+6 are decoded. A read of any other address returns 0, and a write to any other address changes no register and starts no operation.
- R2: A write to BASE+0 sets outgoing data bits [15:0]. A read of BASE+0 returns captured data bits [15:0].
- R3: A write to BASE+2 takes outgoing data bits [23:16] from its low byte. A read of BASE+2 returns the following fields:
  - bits [7:0]: captured data bits [23:16]
  - bits [13:8]: lam_in[21:16]
  - bit 14: ext_lam
  - bit 15: inf_in
- R4: A read of BASE+4 returns the following fields, with all other bits 0:
  - bit 0: the captured Q
  - bit 1: the captured X
  - bit 2: the OR of all lam_in lines and ext_lam
  - bit 3: the busy flag

  A write to BASE+4 loads inhibit_o from bit 0 and outf_o from bit 1.
- R5: The command word written to BASE+6 has the following fields:
  - bits [4:0]: function F
  - bits [8:5]: subaddress A
  - bits [13:9]: station N
  - bit 14: Z
  - bit 15: C

  During an addressed operation dw_n, dw_a and dw_f carry these fields. A read of BASE+6 returns lam_in[15:0].
- R6: Writes to BASE+0, BASE+2 and BASE+4 never start an operation. busy_o rises only on the clock after a BASE+6 write.
- R7: An operation holds busy_o for T_SETUP+T_S1+T_GAP+T_S2+T_TAIL clocks. Within that time dw_s1 is high for T_S1 clocks and dw_s2 for T_S2 clocks, and never both at once.
- R8: On an addressed operation, Q and X are captured at the end of S1. Data is captured only when the function is a read (F[4]=0 and F[3]=0). Other functions leave the captured data unchanged.
- R9: dw_wdata carries the staged 24-bit data only during an addressed operation with a write function (F[4]=1 and F[3]=0). At all other times it is 0.
- R10: When C or Z is set, dw_c and/or dw_z follow those bits for the whole operation. In that case dw_n, dw_a and dw_f stay 0, and nothing is captured.
- R11: A BASE+6 write while busy_o is high is ignored. The running operation keeps its fields and its length, and no second operation follows.
- R12: After reset the following are all 0: captured data, Q, X, inhibit_o, outf_o, busy_o, both strobes and dw_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one clock |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Read data for io_addr, combinational |
| dw_rdata | input | 24 | Dataway read lines |
| dw_q | input | 1 | Q response |
| dw_x | input | 1 | X response |
| lam_in | input | 22 | LAM request lines L1..L22 |
| ext_lam | input | 1 | External LAM input |
| inf_in | input | 1 | General input flag |
| dw_n | output | 5 | Station number |
| dw_a | output | 4 | Subaddress |
| dw_f | output | 5 | Function code |
| dw_c | output | 1 | Clear line |
| dw_z | output | 1 | Initialise line |
| dw_s1 | output | 1 | Strobe S1 |
| dw_s2 | output | 1 | Strobe S2 |
| dw_wdata | output | 24 | Dataway write lines |
| inhibit_o | output | 1 | Inhibit line |
| outf_o | output | 1 | General output flag |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions assume the host pulses io_wr for a single clock with a stable address. They also assume dw_rdata, dw_q and dw_x stay constant through the S1 window, since the capture happens at its final clock. The stimulus meets both conditions: every host access goes through a one-clock write task, and the response lines are set before each command write and not touched until busy_o falls. Commands written during a running operation are injected deliberately, so that the rule about ignoring them is exercised. The random command words cover read, write and control functions, and C or Z appears in roughly a quarter of them.

// File: rtl/camac_host_pkg.sv
package camac_host_pkg;
  localparam int DATA_W = 24;
  localparam int LAM_W  = 22;

  typedef struct packed {
    logic       clr;
    logic       ini;
    logic [4:0] stn;
    logic [3:0] sub;
    logic [4:0] fn;
  } cmd_word_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_S1, PH_GAP, PH_S2, PH_TAIL
  } phase_t;

  function automatic logic fn_is_write(input logic [4:0] fn);
    return fn[4] & ~fn[3];
  endfunction

  function automatic logic fn_is_read(input logic [4:0] fn);
    return ~fn[4] & ~fn[3];
  endfunction

  function automatic logic cmd_unaddressed(input cmd_word_t w);
    return w.clr | w.ini;
  endfunction
endpackage

// File: rtl/camac_host_regs.sv
module camac_host_regs
  import camac_host_pkg::*;
#(
  parameter logic [15:0] BASE = 16'h0360
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         io_addr,
  input  logic                io_wr,
  input  logic [15:0]         io_wdata,
  output logic [15:0]         io_rdata,
  input  logic                busy,
  input  logic                strobe1,
  input  logic                cap_qx,
  input  logic                cap_data,
  input  logic [DATA_W-1:0]   dw_rdata,
  input  logic                dw_q,
  input  logic                dw_x,
  input  logic [LAM_W-1:0]    lam_in,
  input  logic                ext_lam,
  input  logic                inf_in,
  output logic [DATA_W-1:0]   stage_data,
  output logic                inhibit_q,
  output logic                outf_q,
  output logic                cmd_wr,
  output cmd_word_t           cmd_word
);
  localparam int NREG = 4;

  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] cap_q;
  logic              q_q, x_q;
  logic              lam_sum;
  logic              wr_ctl;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i] = (io_addr == BASE + 16'(2 * i));
  end

  assign wr_ctl   = io_wr & hit[2];
  assign cmd_wr   = io_wr & hit[3];
  assign cmd_word = cmd_word_t'(io_wdata);
  assign lam_sum  = (|lam_in) | ext_lam;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_data <= '0;
      inhibit_q  <= 1'b0;
      outf_q     <= 1'b0;
    end else begin
      if (io_wr && hit[0]) stage_data[15:0]  <= io_wdata;
      if (io_wr && hit[1]) stage_data[23:16] <= io_wdata[7:0];
      if (wr_ctl) begin
        inhibit_q <= io_wdata[0];
        outf_q    <= io_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      q_q   <= 1'b0;
      x_q   <= 1'b0;
    end else begin
      if (cap_qx) begin
        q_q <= dw_q;
        x_q <= dw_x;
      end
      if (cap_data) cap_q <= dw_rdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    unique case (1'b1)
      hit[0]: io_rdata = cap_q[15:0];
      hit[1]: io_rdata = {inf_in, ext_lam, lam_in[21:16], cap_q[23:16]};
      hit[2]: io_rdata = {12'b0, busy, lam_sum, x_q, q_q};
      hit[3]: io_rdata = lam_in[15:0];
      default: io_rdata = '0;
    endcase
  end

  // R6: an operation only begins after a command-register write
  a_r6_start_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));
  // R8: capture only happens inside the S1 window
  a_r8_capture_in_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_qx || cap_data) |-> strobe1);
  // R4: Inhibit changes only on a control-register write
  a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctl) |-> $stable(inhibit_q));
endmodule

// File: rtl/camac_host_seq.sv
module camac_host_seq
  import camac_host_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_S1    = 3,
  parameter int unsigned T_GAP   = 2,
  parameter int unsigned T_S2    = 3,
  parameter int unsigned T_TAIL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_word_t         cmd_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [4:0]        dw_n,
  output logic [3:0]        dw_a,
  output logic [4:0]        dw_f,
  output logic              dw_c,
  output logic              dw_z,
  output logic              dw_s1,
  output logic              dw_s2,
  output logic [DATA_W-1:0] dw_wdata,
  output logic              busy,
  output logic              cap_qx,
  output logic              cap_data
);
  localparam int unsigned M1   = (T_SETUP > T_S1) ? T_SETUP : T_S1;
  localparam int unsigned M2   = (T_GAP > T_S2) ? T_GAP : T_S2;
  localparam int unsigned M3   = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXT = (M3 > T_TAIL) ? M3 : T_TAIL;
  localparam int          CW   = (MAXT > 1) ? $clog2(MAXT) : 1;

  phase_t            ph;
  logic [CW-1:0]     cnt;
  cmd_word_t         cmd_q;
  logic [DATA_W-1:0] wd_q;
  logic              addressed;
  logic              phase_done;
  logic              s1_last;

  function automatic logic [CW-1:0] last_idx(input phase_t p);
    case (p)
      PH_SETUP: return CW'(T_SETUP - 1);
      PH_S1:    return CW'(T_S1 - 1);
      PH_GAP:   return CW'(T_GAP - 1);
      PH_S2:    return CW'(T_S2 - 1);
      PH_TAIL:  return CW'(T_TAIL - 1);
      default:  return '0;
    endcase
  endfunction

  function automatic phase_t next_ph(input phase_t p);
    case (p)
      PH_SETUP: return PH_S1;
      PH_S1:    return PH_GAP;
      PH_GAP:   return PH_S2;
      PH_S2:    return PH_TAIL;
      default:  return PH_IDLE;
    endcase
  endfunction

  assign phase_done = (cnt == last_idx(ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      cmd_q <= '0;
      wd_q  <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        ph    <= PH_SETUP;
        cnt   <= '0;
        cmd_q <= cmd_in;
        wd_q  <= wdata_in;
      end
    end else if (phase_done) begin
      ph  <= next_ph(ph);
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy      = (ph != PH_IDLE);
  assign addressed = busy & ~cmd_unaddressed(cmd_q);
  assign dw_s1     = (ph == PH_S1);
  assign dw_s2     = (ph == PH_S2);
  assign dw_n      = addressed ? cmd_q.stn : '0;
  assign dw_a      = addressed ? cmd_q.sub : '0;
  assign dw_f      = addressed ? cmd_q.fn  : '0;
  assign dw_c      = busy & cmd_q.clr;
  assign dw_z      = busy & cmd_q.ini;
  assign dw_wdata  = (addressed && fn_is_write(cmd_q.fn)) ? wd_q : '0;
  assign s1_last   = dw_s1 & phase_done;
  assign cap_qx    = s1_last & addressed;
  assign cap_data  = cap_qx & fn_is_read(cmd_q.fn);

  // R7: the two strobes never overlap
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dw_s1 && dw_s2));
  // R7: strobes only appear inside an operation
  a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_s1 || dw_s2) |-> busy);
  // R11: station field holds for the whole operation
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dw_n) && $stable(dw_f));
  // R10: no capture during a clear or initialise operation
  a_r10_unaddr_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_c || dw_z) |-> !cap_qx && dw_n == 5'd0);
endmodule

// File: rtl/camac_host_ctl.sv
module camac_host_ctl
  import camac_host_pkg::*;
#(
  parameter logic [15:0] BASE    = 16'h0360,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_S1    = 3,
  parameter int unsigned T_GAP   = 2,
  parameter int unsigned T_S2    = 3,
  parameter int unsigned T_TAIL  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic [23:0] dw_rdata,
  input  logic        dw_q,
  input  logic        dw_x,
  input  logic [21:0] lam_in,
  input  logic        ext_lam,
  input  logic        inf_in,
  output logic [4:0]  dw_n,
  output logic [3:0]  dw_a,
  output logic [4:0]  dw_f,
  output logic        dw_c,
  output logic        dw_z,
  output logic        dw_s1,
  output logic        dw_s2,
  output logic [23:0] dw_wdata,
  output logic        inhibit_o,
  output logic        outf_o,
  output logic        busy_o
);
  logic              cmd_wr;
  cmd_word_t         cmd_word;
  logic [DATA_W-1:0] stage_data;
  logic              cap_qx, cap_data;

  camac_host_regs #(.BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .busy(busy_o), .strobe1(dw_s1), .cap_qx(cap_qx), .cap_data(cap_data),
    .dw_rdata(dw_rdata), .dw_q(dw_q), .dw_x(dw_x),
    .lam_in(lam_in), .ext_lam(ext_lam), .inf_in(inf_in),
    .stage_data(stage_data), .inhibit_q(inhibit_o), .outf_q(outf_o),
    .cmd_wr(cmd_wr), .cmd_word(cmd_word)
  );

  camac_host_seq #(
    .T_SETUP(T_SETUP), .T_S1(T_S1), .T_GAP(T_GAP), .T_S2(T_S2), .T_TAIL(T_TAIL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_wr), .cmd_in(cmd_word), .wdata_in(stage_data),
    .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f), .dw_c(dw_c), .dw_z(dw_z),
    .dw_s1(dw_s1), .dw_s2(dw_s2), .dw_wdata(dw_wdata),
    .busy(busy_o), .cap_qx(cap_qx), .cap_data(cap_data)
  );

  // R9: write lines are quiet outside an operation
  a_r9_wdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> dw_wdata == 24'd0);
endmodule

// File: tb/camac_host_ctl_test.sv
`timescale 1ns/1ps
module camac_host_ctl_test;
  localparam logic [15:0] BASE = 16'h0360;
  localparam int TS = 2, T1 = 3, TG = 2, T2 = 3, TT = 1;
  localparam int TOTAL = TS + T1 + TG + T2 + TT;

  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic io_wr = 0;
  wire  [15:0] io_rdata;
  logic [23:0] dw_rdata = 0;
  logic dw_q = 0, dw_x = 0, ext_lam = 0, inf_in = 0;
  logic [21:0] lam_in = 0;
  wire [4:0] dw_n, dw_f;
  wire [3:0] dw_a;
  wire dw_c, dw_z, dw_s1, dw_s2, inhibit_o, outf_o, busy_o;
  wire [23:0] dw_wdata;

  int nchk = 0, nfail = 0;
  logic [23:0] m_data = 0;
  logic m_q = 0, m_x = 0;

  always #2.5 clk = ~clk;

  camac_host_ctl #(.BASE(BASE), .T_SETUP(TS), .T_S1(T1), .T_GAP(TG), .T_S2(T2), .T_TAIL(TT)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .dw_rdata(dw_rdata), .dw_q(dw_q), .dw_x(dw_x), .lam_in(lam_in),
    .ext_lam(ext_lam), .inf_in(inf_in), .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f),
    .dw_c(dw_c), .dw_z(dw_z), .dw_s1(dw_s1), .dw_s2(dw_s2), .dw_wdata(dw_wdata),
    .inhibit_o(inhibit_o), .outf_o(outf_o), .busy_o(busy_o));

  function automatic bit exp_wr_fn(input logic [4:0] f); return f >= 5'd16 && f <= 5'd23; endfunction
  function automatic bit exp_rd_fn(input logic [4:0] f); return f <= 5'd7; endfunction
  function automatic logic [15:0] exp_p2(input logic [23:0] d);
    return {inf_in, ext_lam, lam_in[21:16], d[23:16]};
  endfunction
  function automatic logic [15:0] exp_p4(input logic q, input logic x, input logic b);
    return {12'b0, b, (lam_in != 0) || ext_lam, x, q};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); io_addr = a; io_wr = 0; #1 d = io_rdata;
  endtask

  task automatic run_op(input logic [15:0] cmd, input logic [23:0] wd, input logic [23:0] rdv,
                        input logic q, input logic x, input bit inject);
    int cnt = 0, s1c = 0, s2c = 0, bad_n = 0, bad_wd = 0, bad_cz = 0, overlap = 0;
    bit un = cmd[15] | cmd[14];
    logic [4:0] en = un ? 5'd0 : cmd[13:9];
    logic [23:0] ewd = (!un && exp_wr_fn(cmd[4:0])) ? wd : 24'd0;
    logic [15:0] r;
    wr(BASE, wd[15:0]);
    wr(BASE + 16'd2, {8'h00, wd[23:16]});
    dw_rdata = rdv; dw_q = q; dw_x = x;
    wr(BASE + 16'd6, cmd);
    while (busy_o && cnt < 100) begin
      if (dw_s1) s1c++;
      if (dw_s2) s2c++;
      if (dw_s1 && dw_s2) overlap++;
      if (dw_n !== en || (!un && dw_f !== cmd[4:0]) || (!un && dw_a !== cmd[8:5])) bad_n++;
      if (dw_wdata !== ewd) bad_wd++;
      if (dw_c !== cmd[15] || dw_z !== cmd[14]) bad_cz++;
      if (inject && cnt == 3) begin
        io_addr = BASE + 16'd6; io_wdata = cmd ^ 16'h3E1F; io_wr = 1;
      end else io_wr = 0;
      @(negedge clk);
      cnt++;
    end
    io_wr = 0;
    chk("R7 busy length", cnt, TOTAL);
    chk("R7 S1 length", s1c, T1);
    chk("R7 S2 length", s2c, T2);
    chk("R7 strobe overlap", overlap, 0);
    chk(inject ? "R11 fields held" : "R5 NAF fields", bad_n, 0);
    chk("R9 write lines", bad_wd, 0);
    chk("R10 C/Z lines", bad_cz, 0);
    if (!un) begin
      m_q = q; m_x = x;
      if (exp_rd_fn(cmd[4:0])) m_data = rdv;
    end
    dw_rdata = ~rdv;
    rd(BASE, r);           chk("R8 R2 data low", r, m_data[15:0]);
    rd(BASE + 16'd2, r);   chk("R8 R3 data high", r, exp_p2(m_data));
    rd(BASE + 16'd4, r);   chk("R8 R4 Q/X", r, exp_p4(m_q, m_x, 1'b0));
    chk(inject ? "R11 no second op" : "R6 idle after op", busy_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy_o, 0);
    chk("R12 strobes", {dw_s1, dw_s2}, 0);
    chk("R12 inhibit/outf", {inhibit_o, outf_o}, 0);
    chk("R12 wdata", dw_wdata, 0);
    rst_n = 1;
    rd(BASE, r);          chk("R12 data", r, 0);
    rd(BASE + 16'd4, r);  chk("R12 Q/X", r, exp_p4(0, 0, 0));

    // R4 control register
    wr(BASE + 16'd4, 16'h0003); chk("R4 inhibit/outf set", {inhibit_o, outf_o}, 2'b11);
    wr(BASE + 16'd4, 16'h0002); chk("R4 inhibit clear", {inhibit_o, outf_o}, 2'b01);
    // R1 unmapped address
    wr(BASE + 16'd8, 16'hFFFF); chk("R1 unmapped write", {inhibit_o, outf_o}, 2'b01);
    chk("R1 unmapped no op", busy_o, 0);
    wr(BASE + 16'd1, 16'h0001); chk("R1 odd address write", {inhibit_o, outf_o}, 2'b01);
    lam_in = 22'h2AAAAA;
    rd(BASE + 16'd8, r);  chk("R1 unmapped read", r, 0);
    rd(BASE + 16'd6, r);  chk("R5 LAM low read", r, 16'hAAAA);
    lam_in = 0; ext_lam = 1; inf_in = 1;
    rd(BASE + 16'd2, r);  chk("R3 status bits", r, exp_p2(m_data));
    rd(BASE + 16'd4, r);  chk("R4 summary LAM", r, exp_p4(0, 0, 0));
    ext_lam = 0; inf_in = 0;
    // R6 other writes never start
    wr(BASE, 16'hFFFF);          chk("R6 port0 write no op", busy_o, 0);
    wr(BASE + 16'd2, 16'hFFFF);  chk("R6 port2 write no op", busy_o, 0);
    wr(BASE + 16'd4, 16'h0000);  chk("R6 port4 write no op", busy_o, 0);

    // directed: read, write (data kept), clear, initialise, busy-injection
    run_op({2'b00, 5'd3, 4'd2, 5'd0},  24'h123456, 24'hABCDEF, 1, 0, 0);
    run_op({2'b00, 5'd7, 4'd1, 5'd16}, 24'h0F0F0F, 24'h111111, 0, 1, 0);
    run_op({2'b10, 5'd9, 4'd9, 5'd0},  24'h777777, 24'h222222, 1, 1, 0);
    run_op({2'b01, 5'd1, 4'd1, 5'd16}, 24'h888888, 24'h333333, 0, 0, 0);
    run_op({2'b00, 5'd4, 4'd0, 5'd26}, 24'h999999, 24'h444444, 1, 1, 1);

    // R8 read via random stimulus
    for (int i = 0; i < 30; i++) begin
      logic [15:0] cmd = 16'($urandom);
      cmd[15] = ($urandom % 8) == 0;
      cmd[14] = ($urandom % 8) == 0;
      lam_in = 22'($urandom); ext_lam = 1'($urandom); inf_in = 1'($urandom);
      run_op(cmd, 24'($urandom), 24'($urandom), 1'($urandom), 1'($urandom), (i % 5) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule